// File: doc/BRIEF.md
# Quad-SPI flash read responder

This block is a synthesizable stand-in for a serial flash device that can only answer read commands. It sits on the device side of a four-line serial bus. It watches the serial clock, the active-low chip select and the host's data line IO0, all sampled by its own system clock. A transaction has three parts: an eight-bit opcode, a 24-bit start address and a fixed number of dummy clocks. After that the block streams bytes from an internal ROM on one, two or four lanes, depending on the opcode.

The ROM holds a parameterised number of bytes, and that number must be a power of two. Its contents are computed from two parameters, so the contents are known without any loading step. Reading starts at the received address and moves up one byte at a time, wrapping to zero at the end of the ROM, until the host stops clocking or deselects the device. The block never drives a lane before the data phase. In single-lane mode it leaves IO0 to the host.

The block drives its pins directly. There is no stream interface and so no back-pressure. The host controls the pace entirely through the serial clock. The internal pipeline from an SCK edge to a new output value is three system clocks long, so each half period of SCK must be at least four system clocks, which means an SCK period of eight system clocks or more. The bench uses sixteen.

Top module: `qspi_read_responder`

## Requirements
- R1: After reset, and whenever chip select is high, `io_oe` is 4'b0000 and `io_out` is 4'b0000.
- R2: The opcode is taken from `io0_in` on eight SCK rising edges, most significant bit first. 8'h0B selects a one-lane read, 8'h3B a two-lane read and 8'h6B a four-lane read. Any other opcode leaves every output enable low until chip select goes high, however many clocks follow.
- R3: Twenty-four address bits follow on `io0_in`, most significant bit first. Only the low log2(ROM_DEPTH) bits select the first byte, so with the default depth of 32, address 24'h123447 reads from index 7.
- R4: `io_oe` stays 0 through the opcode, the address and the dummy clocks. There are 8 dummy clocks for 8'h0B and 4 for 8'h3B and 8'h6B. The first data unit is presented after the SCK falling edge that follows the last dummy rising edge.
- R5: In one-lane mode, data appears on `io_out[1]` only, one bit per SCK, most significant bit first, with `io_oe` = 4'b0010.
- R6: In two-lane mode, `io_out[1:0]` carries two bits per SCK, with the upper pair first and bit 7 on lane 1. `io_oe` is 4'b0011.
- R7: In four-lane mode, `io_out[3:0]` carries one nibble per SCK, upper nibble first, with `io_oe` = 4'b1111.
- R8: After each byte the index moves up by one, and after ROM_DEPTH-1 it continues at 0, for as long as the host keeps clocking.
- R9: Outputs change only after an SCK falling edge, so they hold steady while SCK is high and can be sampled on the rising edge.
- R10: When chip select goes high, all enables are released within three system clocks, and the next selection starts with a fresh opcode.
- R11: ROM byte i equals (i*ROM_MUL + ROM_ADD) mod 256. The defaults are ROM_MUL=29 and ROM_ADD=60.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCK period must be at least 8 of these |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select from the host |
| io0_in | input | 1 | Host-driven IO0 carrying opcode and address |
| io_out | output | 4 | Output values for IO3..IO0 |
| io_oe | output | 4 | Per-lane output enables for IO3..IO0 |

## Verification
A wrong phase or bit counter shows up at the SCK edge where the data phase should begin. An enable that is late, early or on the wrong lanes is seen in the first sampled unit, which is no more than about eight SCK cycles after the address. A wrong address or wrong unit order shows as a bad first byte. A broken increment or wrap appears at the next byte boundary, one to eight SCK cycles later. A broken deselect path shows within a few system clocks as enables still high after chip select rises, and then as a failed read on the next selection.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
  localparam logic [7:0] OP_READ_X1 = 8'h0B;
  localparam logic [7:0] OP_READ_X2 = 8'h3B;
  localparam logic [7:0] OP_READ_X4 = 8'h6B;

  typedef enum logic [2:0] {
    PH_CMD    = 3'd0,
    PH_ADDR   = 3'd1,
    PH_DUMMY  = 3'd2,
    PH_DATA   = 3'd3,
    PH_IGNORE = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    LANE_1 = 2'd0,
    LANE_2 = 2'd1,
    LANE_4 = 2'd2
  } lane_t;
endpackage

// File: rtl/qspi_pin_sync.sv
module qspi_pin_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qspi_rd_rom.sv
module qspi_rd_rom #(
  parameter int ROM_DEPTH = 32,
  parameter int ROM_MUL = 29,
  parameter int ROM_ADD = 60,
  localparam int AW = $clog2(ROM_DEPTH)
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    data
);
  logic [7:0] mem [ROM_DEPTH];

  genvar i;
  generate
    for (i = 0; i < ROM_DEPTH; i++) begin : g_byte
      assign mem[i] = 8'((i * ROM_MUL + ROM_ADD) % 256);
    end
  endgenerate

  assign data = mem[addr];
endmodule

// File: rtl/qspi_rd_shifter.sv
module qspi_rd_shifter
  import qspi_rd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          data_en,
  input  logic          fall,
  input  lane_t         lane,
  input  logic [AW-1:0] start_addr,
  input  logic [7:0]    rom_data,
  output logic [AW-1:0] rom_addr,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe
);
  logic          started;
  logic [7:0]    shreg;
  logic [2:0]    unit_cnt;
  logic [AW-1:0] addr;

  logic [2:0] last_unit;
  logic [7:0] shifted;
  logic [3:0] pins;
  logic [3:0] oe_pat;

  always_comb begin
    case (lane)
      LANE_1: begin
        last_unit = 3'd7;
        shifted   = {shreg[6:0], 1'b0};
        pins      = {2'b00, shreg[7], 1'b0};
        oe_pat    = 4'b0010;
      end
      LANE_2: begin
        last_unit = 3'd3;
        shifted   = {shreg[5:0], 2'b00};
        pins      = {2'b00, shreg[7:6]};
        oe_pat    = 4'b0011;
      end
      default: begin
        last_unit = 3'd1;
        shifted   = {shreg[3:0], 4'b0000};
        pins      = shreg[7:4];
        oe_pat    = 4'b1111;
      end
    endcase
  end

  assign rom_addr = started ? AW'(addr + 1'b1) : start_addr;
  assign io_out   = started ? pins : 4'b0000;
  assign io_oe    = started ? oe_pat : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      shreg    <= '0;
      unit_cnt <= '0;
      addr     <= '0;
    end else if (clear) begin
      started  <= 1'b0;
      unit_cnt <= '0;
    end else if (fall && data_en) begin
      if (!started) begin
        started  <= 1'b1;
        shreg    <= rom_data;
        addr     <= start_addr;
        unit_cnt <= '0;
      end else if (unit_cnt == last_unit) begin
        shreg    <= rom_data;
        addr     <= rom_addr;
        unit_cnt <= '0;
      end else begin
        shreg    <= shifted;
        unit_cnt <= unit_cnt + 3'd1;
      end
    end
  end

  // R5
  lane_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0010) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

  // R9
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !clear) |=> ($stable(io_out) && $stable(io_oe)));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (io_oe == 4'b0000));
endmodule

// File: rtl/qspi_read_responder.sv
module qspi_read_responder
  import qspi_rd_pkg::*;
#(
  parameter int ROM_DEPTH = 32,
  parameter int ROM_MUL = 29,
  parameter int ROM_ADD = 60,
  parameter int ADDR_BITS = 24,
  parameter int DUMMY_X1 = 8,
  parameter int DUMMY_WIDE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       io0_in,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);
  localparam int AW = $clog2(ROM_DEPTH);
  localparam int CW = $clog2(ADDR_BITS);

  logic [2:0] pins_s;
  logic sck_s, cs_hi, io0_s, sck_q;
  logic rise, fall;

  qspi_pin_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({io0_in, cs_n, sck}), .q(pins_s)
  );
  assign {io0_s, cs_hi, sck_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else sck_q <= sck_s;
  end
  assign rise = sck_s & ~sck_q & ~cs_hi;
  assign fall = ~sck_s & sck_q & ~cs_hi;

  phase_t        phase;
  lane_t         lane;
  logic [CW-1:0] bit_cnt;
  logic [CW-1:0] dummy_last;
  logic [6:0]    cmd_sr;
  logic [AW-1:0] addr_sr;
  logic [7:0]    opcode;

  assign opcode = {cmd_sr, io0_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      lane       <= LANE_1;
      bit_cnt    <= '0;
      dummy_last <= '0;
      cmd_sr     <= '0;
      addr_sr    <= '0;
    end else if (cs_hi) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
    end else if (rise) begin
      case (phase)
        PH_CMD: begin
          cmd_sr <= opcode[6:0];
          if (bit_cnt == CW'(7)) begin
            bit_cnt <= '0;
            phase   <= PH_ADDR;
            case (opcode)
              OP_READ_X1: begin lane <= LANE_1; dummy_last <= CW'(DUMMY_X1 - 1); end
              OP_READ_X2: begin lane <= LANE_2; dummy_last <= CW'(DUMMY_WIDE - 1); end
              OP_READ_X4: begin lane <= LANE_4; dummy_last <= CW'(DUMMY_WIDE - 1); end
              default:    phase <= PH_IGNORE;
            endcase
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          addr_sr <= {addr_sr[AW-2:0], io0_s};
          if (bit_cnt == CW'(ADDR_BITS - 1)) begin
            bit_cnt <= '0;
            phase   <= PH_DUMMY;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (bit_cnt == dummy_last) phase <= PH_DATA;
          else bit_cnt <= bit_cnt + 1'b1;
        end
        default: phase <= phase;
      endcase
    end
  end

  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data;

  qspi_rd_rom #(.ROM_DEPTH(ROM_DEPTH), .ROM_MUL(ROM_MUL), .ROM_ADD(ROM_ADD)) u_rom (
    .addr(rom_addr), .data(rom_data)
  );

  qspi_rd_shifter #(.AW(AW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(cs_hi), .data_en(phase == PH_DATA),
    .fall(fall), .lane(lane), .start_addr(addr_sr), .rom_data(rom_data),
    .rom_addr(rom_addr), .io_out(io_out), .io_oe(io_oe)
  );

  // R4
  no_early_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_DATA) |-> (io_oe == 4'b0000));

  // R2
  ignore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE && !cs_hi) |=> (phase == PH_IGNORE));
endmodule

// File: tb/sim_qspi_read_responder.sv
`timescale 1ns/1ps
module sim_qspi_read_responder;
  localparam int DEPTH = 32;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic io0_in = 1'b0;
  logic [3:0] io_out, io_oe;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qspi_read_responder u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .io0_in(io0_in), .io_out(io_out), .io_oe(io_oe)
  );

  function automatic logic [7:0] rom_byte(input int idx);
    return 8'(((idx % DEPTH) * 29 + 60) % 256);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one SCK period: low half with host data, sample, high half, sample again
  task automatic sck_cycle(input logic d0, output logic [3:0] o_pre, output logic [3:0] oe_pre,
                           output logic [3:0] o_post, output logic [3:0] oe_post);
    @(negedge clk);
    sck = 1'b0;
    io0_in = d0;
    repeat (HALF) @(negedge clk);
    o_pre = io_out;
    oe_pre = io_oe;
    sck = 1'b1;
    repeat (HALF - 1) @(negedge clk);
    o_post = io_out;
    oe_post = io_oe;
  endtask

  task automatic select();
    @(negedge clk);
    sck = 1'b0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic deselect(input string req);
    @(negedge clk);
    sck = 1'b0;
    cs_n = 1'b1;
    io0_in = 1'b0;
    repeat (6) @(negedge clk);
    check(req, {io_oe, io_out}, 8'h00);
  endtask

  // sends opcode and address; returns OR of oe seen during them
  task automatic send_header(input logic [7:0] op, input logic [23:0] addr, output logic [3:0] oe_seen);
    logic [3:0] a, b, c, e;
    oe_seen = 4'b0;
    for (int i = 7; i >= 0; i--) begin
      sck_cycle(op[i], a, b, c, e);
      oe_seen = oe_seen | b | e;
    end
    for (int i = 23; i >= 0; i--) begin
      sck_cycle(addr[i], a, b, c, e);
      oe_seen = oe_seen | b | e;
    end
  endtask

  task automatic read_check(input logic [7:0] op, input logic [23:0] addr, input int nbytes,
                            input string req);
    logic [3:0] a, b, c, e, oe_seen;
    int lanes, dummies;
    logic [3:0] exp_oe;
    logic [7:0] got;
    logic stable_ok;
    lanes   = (op == 8'h0B) ? 1 : (op == 8'h3B) ? 2 : 4;
    dummies = (op == 8'h0B) ? 8 : 4;
    exp_oe  = (lanes == 1) ? 4'b0010 : (lanes == 2) ? 4'b0011 : 4'b1111;
    select();
    send_header(op, addr, oe_seen);
    for (int i = 0; i < dummies; i++) begin
      sck_cycle(1'b0, a, b, c, e);
      oe_seen = oe_seen | b | e;
    end
    // R4: nothing driven before the data phase
    check({req, " R4 header/dummy oe"}, {28'd0, oe_seen}, 32'd0);
    for (int k = 0; k < nbytes; k++) begin
      got = 8'h00;
      stable_ok = 1'b1;
      for (int u = 0; u < 8 / lanes; u++) begin
        sck_cycle(1'b0, a, b, c, e);
        if (b !== exp_oe) stable_ok = 1'b0;
        // R9: value held through the high half of SCK
        if ((a !== c) || (b !== e)) stable_ok = 1'b0;
        if (lanes == 1) got = {got[6:0], a[1]};
        else if (lanes == 2) got = {got[5:0], a[1:0]};
        else got = {got[3:0], a[3:0]};
      end
      check({req, " R9 lanes/stability"}, {31'd0, stable_ok}, 32'd1);
      check({req, " R8 R11 data byte"}, {24'd0, got}, {24'd0, rom_byte(int'(addr % DEPTH) + k)});
    end
    deselect({req, " R10 release"});
  endtask

  task automatic test_reset();
    check("R1 reset outputs", {24'd0, io_oe, io_out}, 32'd0);
  endtask

  task automatic test_single();
    read_check(8'h0B, 24'h000005, 4, "R5 single");
  endtask

  task automatic test_dual();
    read_check(8'h3B, 24'h000010, 4, "R6 dual");
  endtask

  task automatic test_quad_wrap();
    read_check(8'h6B, 24'h00001E, 5, "R7 R8 quad wrap");
  endtask

  task automatic test_alias();
    read_check(8'h0B, 24'h123447, 2, "R3 alias");
  endtask

  task automatic test_unknown();
    logic [3:0] a, b, c, e, seen;
    select();
    send_header(8'h9F, 24'h000000, seen);
    for (int i = 0; i < 40; i++) begin
      sck_cycle(i[0], a, b, c, e);
      seen = seen | b | e | a | c;
    end
    check("R2 unknown opcode silent", {28'd0, seen}, 32'd0);
    deselect("R2 deselect");
  endtask

  task automatic test_abort();
    logic [3:0] a, b, c, e, seen;
    select();
    send_header(8'h6B, 24'h000003, seen);
    for (int i = 0; i < 4; i++) sck_cycle(1'b0, a, b, c, e);
    sck_cycle(1'b0, a, b, c, e);
    check("R7 abort first nibble", {28'd0, a}, {28'd0, rom_byte(3) >> 4});
    @(negedge clk);
    sck = 1'b0;
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 release within 3 clocks", {28'd0, io_oe}, 32'd0);
    repeat (4) @(negedge clk);
    read_check(8'h3B, 24'h00001F, 2, "R10 fresh command");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_single();
    test_dual();
    test_quad_wrap();
    test_unknown();
    test_abort();
    test_alias();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule